// File: doc/BRIEF.md
# Multiplierless Polyphase Matched Filterbank

This block is the matched filter and fractional-delay interpolator of a symbol timing recovery loop. It holds a bank of polyphase sub-filters, all cut from one pulse-shaping prototype. It accepts one signed sample per clock. With each sample it also takes a phase index from the loop's interpolation control. That index picks the sub-filter whose fractional delay lies closest to the wanted sampling instant. The filtered sample for that phase leaves the block a fixed number of cycles later.

No multipliers are used. The tap delay line is read one bit position at a time. Each group of four taps at one bit position addresses a 16-entry table. The table holds the sum of the coefficients for every combination of the four bits. The table outputs of the selected phase are summed and then weighted by powers of two through shifts. The slice for the sign bit is subtracted instead of added. The result is rounded, scaled and clipped to the output width. The coefficients are fixed constants computed at elaboration time. With the defaults there are 8 phases of 13 taps, 12-bit inputs, 16-bit coefficients and 16-bit outputs.

Top module: `dafb_polyphase_mf`

## Requirements
- R1: `out_valid` is high exactly 5 clock edges after the edge that accepted a sample with `in_valid` high. That is one output per accepted sample, including back-to-back samples on every clock.
- R2: For each accepted sample the output is y = sum over t = 0..12 of c(p,t)·x[t], followed by the scaling of R7 and the clipping of R8. Here p is the phase index given with that sample, x[0] is that sample, x[t] is the sample accepted t samples earlier, and positions not yet filled since reset count as zero.
- R3: The coefficient of phase p and tap t is c(p,t) = 5·(1600 − d²) with d = 8t + p − 52. For example, an impulse fed through phase p reproduces c(p,0), c(p,1), … after scaling.
- R4: The phase index is bound to the sample it arrives with. Changing the index on every sample gives each output the sub-filter of its own sample.
- R5: A cycle with `in_valid` low changes nothing. Its sample and phase values do not enter the delay line and do not affect any later output.
- R6: Inputs are two's complement. Negative samples, including the most negative value −2048, give the correctly signed product sums.
- R7: Scaling is round-half-up: out = floor((y + 1024) / 2048). For example, y = 5120 gives 3 and y = −5120 gives −2.
- R8: Scaled values above 32767 give 32767, and values below −32768 give −32768.
- R9: During and right after reset, `out_valid` is 0, `out_sample` is 0, and the delay line is all zero.
- R10: `out_sample` keeps its last value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | 12 | Two's complement input sample |
| in_phase | input | 3 | Sub-filter (phase) index for this sample |
| out_valid | output | 1 | `out_sample` holds a new result |
| out_sample | output | 16 | Rounded, clipped filter output |

## Verification
The bench targets four corner cases, and each one catches a different kind of fault:
- Unit impulses of ±1 on the phase whose tap hits exactly half a least-significant bit. A truncating or round-to-even scaler lands one code off.
- Full-scale runs of +2047 and −2048. These reach both clipping rails. A design that drops saturation wraps around, and a sign-bit slice added instead of subtracted flips the sign.
- Random phase changes on every sample. These expose an index that is not delayed together with its data, which would apply the neighbouring sample's sub-filter.
- Idle gaps filled with random data. These catch a delay line that shifts without a valid sample, and an output register that changes while `out_valid` is low.

// File: rtl/dafb_pkg.sv
package dafb_pkg;

  // taps sharing one lookup table
  localparam int DA_GRP    = 4;
  localparam int COEF_GAIN = 5;
  localparam int COEF_RAD  = 40;

  // prototype coefficient for one phase/tap pair
  function automatic int proto_coef(int phases, int taps, int phase, int tap);
    int d;
    d = tap * phases + phase - (phases * taps) / 2;
    return COEF_GAIN * (COEF_RAD * COEF_RAD - d * d);
  endfunction

  // table content: sum of the group's coefficients whose address bit is set
  function automatic int lut_sum(int phases, int taps, int phase, int grp, int addr);
    int s;
    int t;
    s = 0;
    for (int k = 0; k < DA_GRP; k++) begin
      t = grp * DA_GRP + k;
      if ((((addr >> k) & 1) == 1) && (t < taps))
        s = s + proto_coef(phases, taps, phase, t);
    end
    return s;
  endfunction

endpackage

// File: rtl/dafb_lut.sv
module dafb_lut
  import dafb_pkg::*;
#(
  parameter int PHASES = 8,
  parameter int TAPS   = 13,
  parameter int PH     = 0,
  parameter int GRP_ID = 0,
  parameter int SL_W   = 20
) (
  input  logic [DA_GRP-1:0]     addr,
  output logic signed [SL_W-1:0] val
);

  always_comb begin
    val = SL_W'(lut_sum(PHASES, TAPS, PH, GRP_ID, int'(addr)));
  end

endmodule

// File: rtl/dafb_tapline.sv
module dafb_tapline #(
  parameter int TAPS = 13,
  parameter int IN_W = 12,
  parameter int PH_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [IN_W-1:0]            in_sample,
  input  logic [PH_W-1:0]            in_phase,
  output logic [TAPS-1:0][IN_W-1:0]  taps_q,
  output logic [PH_W-1:0]            phase_q,
  output logic                       vld_q
);

  logic [TAPS-1:0][IN_W-1:0] taps_d;
  logic [PH_W-1:0]           phase_d;

  always_comb begin
    taps_d  = taps_q;
    phase_d = phase_q;
    if (in_valid) begin
      taps_d  = {taps_q[TAPS-2:0], in_sample};
      phase_d = in_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q  <= '0;
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      taps_q  <= taps_d;
      phase_q <= phase_d;
      vld_q   <= in_valid;
    end
  end

  // R5
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(taps_q));

  // R2
  newest_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taps_q[0] == $past(in_sample)) && (taps_q[1] == $past(taps_q[0])));

  // R4
  phase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (phase_q == $past(in_phase)) && vld_q);

endmodule

// File: rtl/dafb_slice_stage.sv
module dafb_slice_stage
  import dafb_pkg::*;
#(
  parameter int PHASES = 8,
  parameter int TAPS   = 13,
  parameter int IN_W   = 12,
  parameter int PH_W   = 3,
  parameter int SL_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vld_in,
  input  logic [PH_W-1:0]            phase_in,
  input  logic [TAPS-1:0][IN_W-1:0]  taps_in,
  output logic [IN_W-1:0][SL_W-1:0]  slice_q,
  output logic                       vld_q
);

  localparam int GROUPS = (TAPS + DA_GRP - 1) / DA_GRP;

  logic [SL_W-1:0]           lut_q [PHASES][GROUPS][IN_W];
  logic [IN_W-1:0][SL_W-1:0] slice_d;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < IN_W; b++) begin : g_bit
      logic [DA_GRP-1:0] a;
      for (genvar k = 0; k < DA_GRP; k++) begin : g_k
        if (g * DA_GRP + k < TAPS) begin : g_live
          assign a[k] = taps_in[g*DA_GRP+k][b];
        end else begin : g_pad
          assign a[k] = 1'b0;
        end
      end
      for (genvar p = 0; p < PHASES; p++) begin : g_ph
        dafb_lut #(
          .PHASES(PHASES), .TAPS(TAPS), .PH(p), .GRP_ID(g), .SL_W(SL_W)
        ) u_lut (
          .addr(a),
          .val (lut_q[p][g][b])
        );
      end
    end
  end

  // pipeline 1: phase multiplexer and sum over tap groups, per bit
  always_comb begin
    for (int b = 0; b < IN_W; b++) begin
      slice_d[b] = '0;
      for (int g = 0; g < GROUPS; g++)
        slice_d[b] = slice_d[b] + lut_q[phase_in][g][b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= vld_in;
      if (vld_in) slice_q <= slice_d;
    end
  end

  // R1
  slice_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> vld_q);

endmodule

// File: rtl/dafb_combine.sv
module dafb_combine #(
  parameter int IN_W  = 12,
  parameter int SL_W  = 20,
  parameter int ACC_W = 33
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vld_in,
  input  logic [IN_W-1:0][SL_W-1:0] slice_in,
  output logic signed [ACC_W-1:0]   acc_q,
  output logic                      vld_q
);

  localparam int NPAIR = (IN_W + 1) / 2;

  logic signed [ACC_W-1:0] pair_d [NPAIR];
  logic signed [ACC_W-1:0] pair_q [NPAIR];
  logic                    vld2_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] term;

  // pipeline 2: weight each bit slice by its power of two; sign slice negative
  always_comb begin
    for (int j = 0; j < NPAIR; j++) pair_d[j] = '0;
    for (int b = 0; b < IN_W; b++) begin
      term = ACC_W'($signed(slice_in[b])) <<< b;
      if (b == IN_W - 1) term = -term;
      pair_d[b/2] = pair_d[b/2] + term;
    end
  end

  // pipeline 3: final accumulation
  always_comb begin
    acc_d = '0;
    for (int j = 0; j < NPAIR; j++) acc_d = acc_d + pair_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NPAIR; j++) pair_q[j] <= '0;
      vld2_q <= 1'b0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld2_q <= vld_in;
      vld_q  <= vld2_q;
      if (vld_in) begin
        for (int j = 0; j < NPAIR; j++) pair_q[j] <= pair_d[j];
      end
      if (vld2_q) acc_q <= acc_d;
    end
  end

  // R1
  combine_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> ##1 vld_q);

  // R6
  zero_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && (slice_in == '0)) |=> ##1 (acc_q == '0));

endmodule

// File: rtl/dafb_outstage.sv
module dafb_outstage #(
  parameter int ACC_W  = 33,
  parameter int OUT_W  = 16,
  parameter int SHIFT  = 11,
  parameter bit SAT_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_in,
  input  logic signed [ACC_W-1:0]  acc_in,
  output logic signed [OUT_W-1:0]  out_q,
  output logic                     vld_q
);

  localparam longint MAX_L  = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam longint MIN_L  = -(longint'(1) <<< (OUT_W - 1));
  localparam longint HALF_L = longint'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(HALF_L);
  localparam logic signed [ACC_W-1:0] MAXV   = ACC_W'(MAX_L);
  localparam logic signed [ACC_W-1:0] MINV   = ACC_W'(MIN_L);
  localparam logic signed [ACC_W-1:0] HI_THR = ACC_W'(((MAX_L + 1) <<< SHIFT) - HALF_L);
  localparam logic signed [ACC_W-1:0] LO_THR = ACC_W'((MIN_L <<< SHIFT) - HALF_L);

  logic signed [ACC_W-1:0] rnd;
  logic signed [ACC_W-1:0] scl;
  logic signed [OUT_W-1:0] out_d;

  // pipeline 4: round half up, scale, optional clip
  always_comb begin
    rnd = acc_in + HALF;
    scl = rnd >>> SHIFT;
  end

  if (SAT_EN) begin : g_sat
    always_comb begin
      if (scl > MAXV)      out_d = MAXV[OUT_W-1:0];
      else if (scl < MINV) out_d = MINV[OUT_W-1:0];
      else                 out_d = scl[OUT_W-1:0];
    end

    // R8
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_in && (acc_in >= HI_THR)) |=> (out_q == MAXV[OUT_W-1:0]));

    // R8
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_in && (acc_in < LO_THR)) |=> (out_q == MINV[OUT_W-1:0]));
  end else begin : g_wrap
    always_comb out_d = scl[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_in;
      if (vld_in) out_q <= out_d;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> $stable(out_q) && !vld_q);

  // R1
  out_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> vld_q);

endmodule

// File: rtl/dafb_polyphase_mf.sv
module dafb_polyphase_mf #(
  parameter  int PHASES    = 8,
  parameter  int TAPS      = 13,
  parameter  int IN_W      = 12,
  parameter  int COEF_W    = 16,
  parameter  int OUT_W     = 16,
  parameter  int OUT_SHIFT = 11,
  parameter  bit SAT_EN    = 1'b1,
  localparam int PH_W      = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  input  logic [PH_W-1:0]  in_phase,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_sample
);

  localparam int SL_W  = COEF_W + $clog2(TAPS);
  localparam int ACC_W = SL_W + IN_W + 1;

  logic [TAPS-1:0][IN_W-1:0] taps;
  logic [PH_W-1:0]           phase0;
  logic                      vld0;
  logic [IN_W-1:0][SL_W-1:0] slices;
  logic                      vld1;
  logic signed [ACC_W-1:0]   acc;
  logic                      vld3;
  logic signed [OUT_W-1:0]   y;

  dafb_tapline #(.TAPS(TAPS), .IN_W(IN_W), .PH_W(PH_W)) u_tapline (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_phase(in_phase), .taps_q(taps), .phase_q(phase0), .vld_q(vld0)
  );

  dafb_slice_stage #(
    .PHASES(PHASES), .TAPS(TAPS), .IN_W(IN_W), .PH_W(PH_W), .SL_W(SL_W)
  ) u_slice (
    .clk(clk), .rst_n(rst_n), .vld_in(vld0), .phase_in(phase0),
    .taps_in(taps), .slice_q(slices), .vld_q(vld1)
  );

  dafb_combine #(.IN_W(IN_W), .SL_W(SL_W), .ACC_W(ACC_W)) u_combine (
    .clk(clk), .rst_n(rst_n), .vld_in(vld1), .slice_in(slices),
    .acc_q(acc), .vld_q(vld3)
  );

  dafb_outstage #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(OUT_SHIFT), .SAT_EN(SAT_EN)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .vld_in(vld3), .acc_in(acc),
    .out_q(y), .vld_q(out_valid)
  );

  assign out_sample = y;

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && (out_sample == '0)));

endmodule

// File: tb/test_dafb_polyphase_mf.sv
`timescale 1ns/1ps
module test_dafb_polyphase_mf;

  localparam int LAT = 5;
  localparam int NT  = 13;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_sample;
  logic [2:0]  in_phase;
  logic        out_valid;
  logic [15:0] out_sample;

  int    n_tests;
  int    n_fail;
  string cur_req;
  int    hist [NT];
  int    expv [LAT];
  int    expy [LAT];
  int    last_y;

  dafb_polyphase_mf i_dafb_polyphase_mf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_phase(in_phase), .out_valid(out_valid), .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ref_coef(int p, int t);
    int d;
    d = 8 * t + p - 52;
    return 5 * (1600 - d * d);
  endfunction

  function automatic int ref_out(int p);
    longint acc;
    acc = 0;
    for (int t = 0; t < NT; t++) acc += longint'(ref_coef(p, t)) * hist[t];
    acc = (acc + 1024) >>> 11;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int s, int p);
    int y;
    in_valid  = v;
    in_sample = s[11:0];
    in_phase  = p[2:0];
    @(posedge clk);
    for (int i = LAT - 1; i > 0; i--) begin
      expv[i] = expv[i-1];
      expy[i] = expy[i-1];
    end
    y = 0;
    if (v) begin
      for (int t = NT - 1; t > 0; t--) hist[t] = hist[t-1];
      hist[0] = s;
      y = ref_out(p);
    end
    expv[0] = int'(v);
    expy[0] = y;
    @(negedge clk);
    check("R1", "out_valid", int'(out_valid), expv[LAT-1]);
    if (expv[LAT-1] != 0) begin
      check(cur_req, "out_sample", int'($signed(out_sample)), expy[LAT-1]);
      last_y = expy[LAT-1];
    end else begin
      check("R10", "held out_sample", int'($signed(out_sample)), last_y);
    end
  endtask

  task automatic impulse(int amp, int p);
    step(1'b1, amp, p);
    for (int i = 0; i < NT + 1; i++) step(1'b1, 0, p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    last_y  = 0;
    for (int i = 0; i < NT; i++) hist[i] = 0;
    for (int i = 0; i < LAT; i++) begin
      expv[i] = 0;
      expy[i] = 0;
    end
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    in_phase  = '0;
    repeat (3) @(negedge clk);
    // R9: quiet outputs while reset is held
    check("R9", "out_valid in reset", int'(out_valid), 0);
    check("R9", "out_sample in reset", int'($signed(out_sample)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "out_valid after reset", int'(out_valid), 0);

    // R3: impulse reads back one phase's coefficients (zero history from R9)
    cur_req = "R3";
    impulse(1000, 3);
    impulse(2047, 7);

    // R7: half-LSB rounding on phase 4, tap 9 (c = 5120)
    cur_req = "R7";
    impulse(1, 4);
    impulse(-1, 4);

    // R6: negative full-scale impulse and small negatives
    cur_req = "R6";
    impulse(-2048, 0);
    for (int i = 0; i < 20; i++) step(1'b1, -1 - (i % 5), 2);

    // R2: random data, fixed phase
    cur_req = "R2";
    for (int i = 0; i < 150; i++) step(1'b1, $urandom_range(0, 1999) - 1000, 0);

    // R4: phase index changes on every sample
    cur_req = "R4";
    for (int i = 0; i < 200; i++)
      step(1'b1, $urandom_range(0, 4095) - 2048, $urandom_range(0, 7));

    // R5: idle cycles carry random junk that must be ignored
    cur_req = "R5";
    for (int i = 0; i < 200; i++)
      step(($urandom_range(0, 1) == 1), $urandom_range(0, 4095) - 2048, $urandom_range(0, 7));

    // R8: both clipping rails
    cur_req = "R8";
    for (int i = 0; i < 20; i++) step(1'b1, 2047, 4);
    check("R8", "positive rail", int'($signed(out_sample)), 32767);
    for (int i = 0; i < 20; i++) step(1'b1, -2048, 4);
    check("R8", "negative rail", int'($signed(out_sample)), -32768);

    // R1: drain, no spurious valid afterwards
    cur_req = "R1";
    for (int i = 0; i < 8; i++) step(1'b0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule